// File: doc/BRIEF.md
# Serial Configuration Port Sequencer

This block loads a programmable device through its slave-serial configuration pins. After a start pulse it switches the target's supply on and waits a settling time. It then holds the active-low program line low for a fixed interval and waits for the target's active-high init-ready line. Once that line is up, the block takes configuration bytes from a valid/ready stream and shifts them out most significant bit first on a divided configuration clock with a data line.

When the requested number of bytes has been sent, the block keeps pulsing the configuration clock until the target raises its done line. Two places have a bounded wait: the init-ready line and the done line. If either bound runs out, the run ends with an error. The run also ends with an error if the stream fails to deliver a byte when one is requested, or delivers a byte that is marked bad. A controlling processor starts a run, watches `busy_o`, and then reads one of the two sticky result flags.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the outputs are: `prog_b_o`=1, `cclk_o`=0, `din_o`=0, `pwr_en_o`=0, `busy_o`=0, `s_ready_o`=0, `done_ok_o`=0, `error_o`=0.
- R2: A `start_i` pulse while idle does four things. It raises `busy_o` and `pwr_en_o`, clears both result flags, and latches `byte_count_i`. The block then keeps `prog_b_o` high for SETTLE_CYC cycles, drives it low for exactly PROG_LOW_CYC cycles, and afterwards keeps `pwr_en_o` high.
- R3: After `prog_b_o` returns high, `init_b_i` is sampled once per cycle through a two-stage synchronizer. No configuration clock pulse is issued before it is seen high.
- R4: If INIT_POLL_LIMIT consecutive samples of `init_b_i` are low, the block returns to idle with `error_o`=1 and issues no clock pulse. With the other waits, `busy_o` is then high for SETTLE_CYC+PROG_LOW_CYC+INIT_POLL_LIMIT cycles.
- R5: Bits go out most significant bit first. Each bit lasts CLK_DIV cycles: `cclk_o` is low for the first CLK_DIV/2 cycles and high for the rest. `din_o` changes only while `cclk_o` is low.
- R6: Exactly the latched number of bytes is sent. Each byte is taken in a one-cycle `s_ready_o` window while `cclk_o` is low. A count of 0 skips the data phase and takes no byte.
- R7: After the last data bit, `cclk_o` keeps pulsing until the synchronized `done_i` is high. The block then returns to idle with `done_ok_o`=1.
- R8: If DONE_PULSE_LIMIT complete clock pulses follow the data and `done_i` has not been seen, the block returns to idle with `error_o`=1. The total pulse count is then 8×bytes+DONE_PULSE_LIMIT.
- R9: If `s_valid_i` is low in an `s_ready_o` cycle (underflow), the run ends at once with `error_o`=1. No further pulse is issued.
- R10: A byte offered with `s_error_i`=1 in an `s_ready_o` cycle is not sent, and the run ends with `error_o`=1.
- R11: `start_i` has no effect while `busy_o` is high. The running transfer keeps its byte count.
- R12: Exactly one result flag is set at the end of a run. It holds until the next accepted start. `din_o` and `cclk_o` are low and `prog_b_o` is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| byte_count_i | input | LEN_W | Number of configuration bytes to send |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte present |
| s_error_i | input | 1 | Stream byte is bad |
| s_ready_o | output | 1 | Byte taken this cycle |
| pwr_en_o | output | 1 | Target supply enable |
| prog_b_o | output | 1 | Active-low program line |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration data |
| init_b_i | input | 1 | Target ready for data (asynchronous) |
| done_i | input | 1 | Target configured (asynchronous) |
| busy_o | output | 1 | Run in progress |
| done_ok_o | output | 1 | Last run completed |
| error_o | output | 1 | Last run failed |

## Verification
The assertions assume that the stream source holds `s_valid_i`, `s_data_i` and `s_error_i` steady through each `s_ready_o` cycle. They also assume that `init_b_i` and `done_i` are level signals held long enough for the two-stage synchronizers. The bench changes every input only on the falling clock edge. It presents each stream byte combinationally from an index, and advances that index only after a byte was taken. A target model in the bench drives the two status lines as steady levels: init-ready is released a set number of cycles after the program pulse, and done rises a set number of clock pulses after the data.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_FETCH,
    ST_SHIFT,
    ST_FLUSH
  } cfg_state_e;
endpackage

// File: rtl/cfg_step_counter.sv
module cfg_step_counter #(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic cclk_o,
  output logic pulse_end_o
);
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run_i)                           ph_d = '0;
    else if (ph_q == PH_W'(CLK_DIV - 1))  ph_d = '0;
    else                                  ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign cclk_o      = run_i && (ph_q >= PH_W'(HALF));
  assign pulse_end_o = run_i && (ph_q == PH_W'(CLK_DIV - 1));

  // R5: a bit period always ends in the high half of the pulse
  a_r5_end_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end_o |-> cclk_o);
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              clr_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]  left_q, left_d;

  always_comb begin
    sreg_d = sreg_q;
    left_d = left_q;
    if (load_i) begin
      sreg_d = data_i;
      left_d = BIT_W'(BYTE_W - 1);
    end else if (shift_i) begin
      sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
      if (left_q != '0) left_d = left_q - BIT_W'(1);
    end else if (clr_i) begin
      sreg_d = '0;
      left_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign bit_o  = sreg_q[BYTE_W-1];
  assign last_o = (left_q == '0);

  // R6: a new byte is only loaded once the previous one is fully sent
  a_r6_load_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> last_o);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int SETTLE_CYC       = 64,
  parameter int PROG_LOW_CYC     = 32,
  parameter int INIT_POLL_LIMIT  = 100000,
  parameter int DONE_PULSE_LIMIT = 100000,
  parameter int CLK_DIV          = 4,
  parameter int LEN_W            = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  byte_count_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_error_i,
  output logic              s_ready_o,
  output logic              pwr_en_o,
  output logic              prog_b_o,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_b_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              done_ok_o,
  output logic              error_o
);
  localparam int MAX_A   = (SETTLE_CYC > PROG_LOW_CYC) ? SETTLE_CYC : PROG_LOW_CYC;
  localparam int MAX_B   = (INIT_POLL_LIMIT > DONE_PULSE_LIMIT) ? INIT_POLL_LIMIT : DONE_PULSE_LIMIT;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cfg_state_e        state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              pwr_q, pwr_d, ok_q, ok_d, err_q, err_d;
  logic              init_s1_q, init_s2_q, done_s1_q, done_s2_q;
  logic              cnt_clr, cnt_inc, load, shift, run, pulse_end, last_bit;
  logic [CNT_W-1:0]  cnt;

  // two-stage synchronizers for the asynchronous target status lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_s1_q <= 1'b0;
      init_s2_q <= 1'b0;
      done_s1_q <= 1'b0;
      done_s2_q <= 1'b0;
    end else begin
      init_s1_q <= init_b_i;
      init_s2_q <= init_s1_q;
      done_s1_q <= done_i;
      done_s2_q <= done_s1_q;
    end
  end

  cfg_step_counter #(.WIDTH(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc), .count_o(cnt));

  assign run = (state_q == ST_SHIFT) || (state_q == ST_FLUSH);

  cfg_cclk_gen #(.CLK_DIV(CLK_DIV)) u_cclk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .cclk_o(cclk_o), .pulse_end_o(pulse_end));

  cfg_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(s_data_i), .shift_i(shift),
    .clr_i(!((state_q == ST_FETCH) || (state_q == ST_SHIFT))),
    .bit_o(din_o), .last_o(last_bit));

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    pwr_d   = pwr_q;
    ok_d    = ok_q;
    err_d   = err_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETTLE;
        cnt_clr = 1'b1;
        pwr_d   = 1'b1;
        ok_d    = 1'b0;
        err_d   = 1'b0;
        rem_d   = byte_count_i;
      end
      ST_SETTLE: if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
        state_d = ST_PROG;
        cnt_clr = 1'b1;
      end else cnt_inc = 1'b1;
      ST_PROG: if (cnt == CNT_W'(PROG_LOW_CYC - 1)) begin
        state_d = ST_WAIT_INIT;
        cnt_clr = 1'b1;
      end else cnt_inc = 1'b1;
      ST_WAIT_INIT: if (init_s2_q) begin
        state_d = (rem_q == '0) ? ST_FLUSH : ST_FETCH;
        cnt_clr = 1'b1;
      end else if (cnt == CNT_W'(INIT_POLL_LIMIT - 1)) begin
        state_d = ST_IDLE;
        err_d   = 1'b1;
      end else cnt_inc = 1'b1;
      ST_FETCH: if (s_valid_i && !s_error_i) begin
        load    = 1'b1;
        rem_d   = rem_q - LEN_W'(1);
        state_d = ST_SHIFT;
      end else begin
        state_d = ST_IDLE;
        err_d   = 1'b1;
      end
      ST_SHIFT: if (pulse_end) begin
        shift = 1'b1;
        if (last_bit) begin
          state_d = (rem_q == '0) ? ST_FLUSH : ST_FETCH;
          cnt_clr = 1'b1;
        end
      end
      ST_FLUSH: if (done_s2_q) begin
        state_d = ST_IDLE;
        ok_d    = 1'b1;
      end else if (pulse_end) begin
        if (cnt == CNT_W'(DONE_PULSE_LIMIT - 1)) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else cnt_inc = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      pwr_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      pwr_q   <= pwr_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign s_ready_o = (state_q == ST_FETCH);
  assign prog_b_o  = (state_q != ST_PROG);
  assign busy_o    = (state_q != ST_IDLE);
  assign pwr_en_o  = pwr_q;
  assign done_ok_o = ok_q;
  assign error_o   = err_q;

  // R5: data moves only while the configuration clock is low
  a_r5_din_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din_o) |-> !cclk_o);
  // R5: data is steady across every rising clock edge
  a_r5_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));
  // R2: program pulse only with power on and the clock parked
  a_r2_prog_powered: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_b_o |-> (pwr_en_o && !cclk_o));
  // R6: bytes are taken with the clock low
  a_r6_fetch_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> !cclk_o);
  // R12: result flags never both set
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok_o && error_o));
  // R12: every run ends with exactly one result
  a_r12_end_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_ok_o ^ error_o));
endmodule

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;
  localparam int SETTLE  = 6;
  localparam int PROGLOW = 5;
  localparam int INITLIM = 20;
  localparam int DONELIM = 10;
  localparam int DIV     = 4;

  logic       clk, rst_n, start_i;
  logic [7:0] byte_count_i, s_data_i;
  logic       s_valid_i, s_error_i, s_ready_o, pwr_en_o, prog_b_o, cclk_o, din_o;
  logic       init_b_i, done_i, busy_o, done_ok_o, error_o;

  int checks, fails;
  int idx, avail, err_idx, nbytes, init_low, init_cnt, done_after, rises;
  int cyc, settle_n, prog_n, restart_at;
  bit take_pending, pwr_all;
  logic [1:0] flags_at_start;
  time rise_t0, rise_t1;
  logic [7:0] tx_mem [16];
  logic [7:0] rx_mem [16];

  assign s_data_i  = tx_mem[idx[3:0]];
  assign s_valid_i = (idx < avail);
  assign s_error_i = (idx == err_idx);

  cfg_serial_loader #(.SETTLE_CYC(SETTLE), .PROG_LOW_CYC(PROGLOW), .INIT_POLL_LIMIT(INITLIM),
    .DONE_PULSE_LIMIT(DONELIM), .CLK_DIV(DIV), .LEN_W(8)) u_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_error_i(s_error_i), .s_ready_o(s_ready_o),
    .pwr_en_o(pwr_en_o), .prog_b_o(prog_b_o), .cclk_o(cclk_o), .din_o(din_o),
    .init_b_i(init_b_i), .done_i(done_i), .busy_o(busy_o), .done_ok_o(done_ok_o),
    .error_o(error_o));

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // target model: capture bits on rising configuration clock
  always @(posedge cclk_o) begin
    if (rises < 128) rx_mem[rises/8][7-(rises%8)] = din_o;
    if (rises == 0) rise_t0 = $time;
    if (rises == 1) rise_t1 = $time;
    rises++;
  end

  // stream index advance and target status lines, all on the falling edge
  initial begin
    init_b_i = 1'b1; done_i = 1'b0; init_cnt = 0; take_pending = 0;
    forever begin
      @(negedge clk);
      if (take_pending) idx++;
      take_pending = s_ready_o && s_valid_i;
      if (!prog_b_o) begin
        init_b_i = 1'b0; init_cnt = 0; done_i = 1'b0;
      end else begin
        if (init_cnt >= init_low) init_b_i = 1'b1;
        else init_cnt++;
        if (done_after >= 0 && rises >= 8*nbytes + done_after) done_i = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int nb, input int av, input int ei, input int il, input int da,
                         input int rs);
    nbytes = nb; avail = av; err_idx = ei; init_low = il; done_after = da; restart_at = rs;
    idx = 0; rises = 0;
    for (int i = 0; i < 16; i++) begin
      tx_mem[i] = 8'(8'hA5 ^ (i * 59));
      rx_mem[i] = 8'h00;
    end
    @(negedge clk); start_i = 1'b1; byte_count_i = 8'(nb);
    @(negedge clk); start_i = 1'b0;
    flags_at_start = {done_ok_o, error_o};
    cyc = 0; settle_n = 0; prog_n = 0; pwr_all = 1;
    while (busy_o && cyc < 5000) begin
      if (!prog_b_o) prog_n++;
      else if (prog_n == 0) settle_n++;
      if (!pwr_en_o) pwr_all = 0;
      cyc++;
      @(negedge clk);
      if (cyc == restart_at) begin start_i = 1'b1; byte_count_i = 8'd7; end
      else start_i = 1'b0;
    end
  endtask

  function automatic int data_mismatches(input int nb);
    int m = 0;
    for (int i = 0; i < nb; i++) if (rx_mem[i] != tx_mem[i]) m++;
    return m;
  endfunction

  task automatic t_reset();
    check(prog_b_o && !cclk_o && !din_o, "R1 pins", {prog_b_o, cclk_o, din_o}, 3'b100);
    check(!pwr_en_o && !busy_o && !s_ready_o, "R1 ctrl", {pwr_en_o, busy_o, s_ready_o}, 0);
    check(!done_ok_o && !error_o, "R1 flags", {done_ok_o, error_o}, 0);
  endtask

  task automatic t_sequence();
    run_cfg(1, 16, 99, 2, 0, -1);
    check(settle_n == SETTLE, "R2 settle cycles", settle_n, SETTLE);
    check(prog_n == PROGLOW, "R2 program low cycles", prog_n, PROGLOW);
    check(pwr_all && pwr_en_o, "R2 power held", pwr_all, 1);
    check(done_ok_o && !error_o, "R7 done result", {done_ok_o, error_o}, 2'b10);
  endtask

  task automatic t_init_timeout();
    run_cfg(2, 16, 99, 1000000, 0, -1);
    check(cyc == SETTLE + PROGLOW + INITLIM, "R4 busy length", cyc, SETTLE + PROGLOW + INITLIM);
    check(error_o && !done_ok_o, "R4 error flag", {done_ok_o, error_o}, 2'b01);
    check(rises == 0, "R4 no pulses", rises, 0);
  endtask

  task automatic t_init_wait_and_restart_flags();
    run_cfg(2, 16, 99, 12, 0, -1);
    check(flags_at_start == 2'b00, "R12 flags cleared at start", flags_at_start, 0);
    check(done_ok_o && data_mismatches(2) == 0, "R3 data after init", data_mismatches(2), 0);
    check(cyc > SETTLE + PROGLOW + 12 + 16 * DIV, "R3 waited for init", cyc,
          SETTLE + PROGLOW + 12 + 16 * DIV);
  endtask

  task automatic t_multi_byte();
    run_cfg(5, 16, 99, 1, 3, -1);
    check(data_mismatches(5) == 0, "R5 msb first data", data_mismatches(5), 0);
    check(rise_t1 - rise_t0 == DIV * 4, "R5 bit period", rise_t1 - rise_t0, DIV * 4);
    check(idx == 5, "R6 bytes taken", idx, 5);
    check(rises >= 43 && rises <= 46, "R7 extra pulses until done", rises, 43);
    check(done_ok_o && !error_o, "R7 result", {done_ok_o, error_o}, 2'b10);
  endtask

  task automatic t_zero_len();
    run_cfg(0, 16, 99, 1, 1, -1);
    check(idx == 0, "R6 zero length takes nothing", idx, 0);
    check(done_ok_o && rises >= 1 && rises <= 4, "R6 zero length flush", rises, 1);
  endtask

  task automatic t_done_timeout();
    run_cfg(1, 16, 99, 1, -1, -1);
    check(error_o && !done_ok_o, "R8 error flag", {done_ok_o, error_o}, 2'b01);
    check(rises == 8 + DONELIM, "R8 pulse count", rises, 8 + DONELIM);
    repeat (5) @(negedge clk);
    check(error_o && !done_ok_o && !busy_o, "R12 flag held", {busy_o, done_ok_o, error_o}, 1);
    check(!din_o && !cclk_o && prog_b_o, "R12 idle levels", {prog_b_o, cclk_o, din_o}, 3'b100);
  endtask

  task automatic t_underflow();
    run_cfg(4, 2, 99, 1, 0, -1);
    check(error_o && !done_ok_o, "R9 error flag", {done_ok_o, error_o}, 2'b01);
    check(rises == 16, "R9 pulses stop", rises, 16);
  endtask

  task automatic t_stream_error();
    run_cfg(3, 16, 1, 1, 0, -1);
    check(error_o && !done_ok_o, "R10 error flag", {done_ok_o, error_o}, 2'b01);
    check(rises == 8, "R10 bad byte not sent", rises, 8);
  endtask

  task automatic t_start_busy();
    run_cfg(2, 16, 99, 1, 0, 25);
    check(idx == 2, "R11 byte count kept", idx, 2);
    check(done_ok_o && data_mismatches(2) == 0, "R11 run unaffected", done_ok_o, 1);
  endtask

  initial begin
    checks = 0; fails = 0; idx = 0; avail = 0; err_idx = 99; nbytes = 0;
    init_low = 0; done_after = -1; rises = 0;
    rst_n = 1'b0; start_i = 1'b0; byte_count_i = 8'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_init_timeout();
    t_init_wait_and_restart_flags();
    t_multi_byte();
    t_zero_len();
    t_done_timeout();
    t_underflow();
    t_stream_error();
    t_start_busy();
    summary();
    $finish;
  end
endmodule